// File: doc/BRIEF.md
# Interrupt Destination Address Matcher

This block tells a local interrupt controller whether an incoming interprocessor or routed interrupt message is meant for it. Each message carries four things: a destination field, a bit that picks physical or logical addressing, a two-bit shorthand, and a flag that is set when the message was sent by this same unit. From these the block drives one combinational match bit.

The block also holds the addressing state that the match depends on. This is an 8-bit local ID, a logical destination word, and a format word that chooses between a flat bitmask model and a cluster model for logical addressing. A simple write port updates this state. An extended-mode input switches the block to wide addressing. In that mode the logical destination is derived from the local ID, the full 32-bit destination is compared, and writes to the three registers are refused.

Sending messages, and choosing one unit when several of them match, are handled elsewhere.

Top module: `dest_match_unit`

## Requirements
- R1: With shorthand 2'b00 the match follows the addressing mode given by the mode bit: 0 selects physical addressing and 1 selects logical addressing.
- R2: With shorthand 2'b01 the match equals the from-self flag, whatever the destination.
- R3: With shorthand 2'b10 the match is always 1.
- R4: With shorthand 2'b11 the match is the inverse of the from-self flag.
- R5: When extended mode is off, physical addressing matches when dest[7:0] is 8'hFF or dest[7:0] equals the local ID. Destination bits 31:8 have no effect.
- R6: When extended mode is off and format bits 31:28 are 4'hF (flat), logical addressing matches when ldr[31:24] AND dest[7:0] is nonzero.
- R7: When extended mode is off and format bits 31:28 are 4'h0 (cluster), logical addressing matches when dest[7:4] equals ldr[31:28] and dest[3:0] AND ldr[27:24] is nonzero.
- R8: When extended mode is off, any other value of format bits 31:28 gives no logical match.
- R9: In extended mode the logical destination in use is ({4'b0,id[7:4]} << 20) | (1 << id[3:0]). Logical addressing matches when that value AND the full 32-bit destination is nonzero.
- R10: In extended mode, physical addressing matches when the full destination equals 32'h000000FF or equals the zero-extended local ID.
- R11: After reset the local ID is RESET_ID, the logical destination is 0, and the format word is all ones (flat). A format write keeps only wr_data[31:28] and forces bits 27:0 to ones.
- R12: Writes use wr_sel 2'b00 to load the ID from wr_data[31:24], 2'b01 to load the logical destination from wr_data, and 2'b10 to load the format word. wr_sel 2'b11 changes nothing. A write takes effect at the next clock edge.
- R13: While extended mode is on, writes to the ID, the logical destination and the format word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_mode | input | 1 | Extended wide-addressing mode enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 32 | Write data |
| msg_dest | input | 32 | Destination field of the message |
| msg_logical | input | 1 | Addressing mode: 0 physical, 1 logical |
| msg_short | input | 2 | Shorthand field |
| msg_from_self | input | 1 | Message was sent by this unit |
| match | output | 1 | This unit is a target of the message |

## Verification
The assertions assume that the message fields and ext_mode are stable and known around each rising clock edge. They also assume that no write arrives in the same cycle as reset. The bench changes every input only at the falling edge and keeps wr_en low while reset is asserted.

Extended mode is held for long stretches and toggled only now and then, so that register state written in legacy mode carries over into extended mode. Destinations are drawn largely from the local ID, the broadcast value and bit patterns close to the stored logical word, so that both matches and near misses occur often.

// File: rtl/dm_pkg.sv
package dm_pkg;

    localparam int ID_W   = 8;
    localparam int DEST_W = 32;
    localparam int NIB_W  = 4;

    typedef enum logic [1:0] {
        SH_DEST   = 2'b00,
        SH_SELF   = 2'b01,
        SH_ALL    = 2'b10,
        SH_OTHERS = 2'b11
    } short_e;

    typedef enum logic [1:0] {
        SEL_ID   = 2'b00,
        SEL_LDR  = 2'b01,
        SEL_FMT  = 2'b10,
        SEL_NONE = 2'b11
    } wsel_e;

    localparam logic [NIB_W-1:0] FMT_FLAT    = 4'hF;
    localparam logic [NIB_W-1:0] FMT_CLUSTER = 4'h0;
    localparam logic [ID_W-1:0]  PHYS_BCAST  = 8'hFF;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [DEST_W-1:0] ldr;
        logic [NIB_W-1:0]  model;
    } cfg_t;

    function automatic logic [DEST_W-1:0] wide_ldr(input logic [ID_W-1:0] id);
        logic [DEST_W-1:0] cl;
        logic [DEST_W-1:0] bit1;
        cl   = DEST_W'(id[ID_W-1:NIB_W]) << 20;
        bit1 = DEST_W'(1) << id[NIB_W-1:0];
        return cl | bit1;
    endfunction

endpackage

// File: rtl/dm_cfg_regs.sv
module dm_cfg_regs
    import dm_pkg::*;
#(
    parameter logic [ID_W-1:0] RESET_ID = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_mode,
    input  logic              wr_en,
    input  wsel_e             wr_sel,
    input  logic [DEST_W-1:0] wr_data,
    output cfg_t              cfg
);

    logic [ID_W-1:0]   id_q;
    logic [DEST_W-1:0] ldr_q;
    logic [NIB_W-1:0]  fmt_q;
    logic              wr_ok;

    assign wr_ok = wr_en && !ext_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q  <= RESET_ID;
            ldr_q <= '0;
            fmt_q <= FMT_FLAT;
        end else if (wr_ok) begin
            unique case (wr_sel)
                SEL_ID:   id_q  <= wr_data[DEST_W-1 -: ID_W];
                SEL_LDR:  ldr_q <= wr_data;
                SEL_FMT:  fmt_q <= wr_data[DEST_W-1 -: NIB_W];
                default:  ;
            endcase
        end
    end

    always_comb begin
        cfg.id    = id_q;
        cfg.ldr   = ext_mode ? wide_ldr(id_q) : ldr_q;
        cfg.model = fmt_q;
    end

    AST_EXT_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (ext_mode && wr_en) |=> ($stable(id_q) && $stable(ldr_q) && $stable(fmt_q))); // R13

    AST_FMT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ext_mode && wr_sel == SEL_FMT) |=> (fmt_q == $past(wr_data[DEST_W-1 -: NIB_W]))); // R11

    AST_NONE_SEL_INERT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_NONE) |=> ($stable(id_q) && $stable(ldr_q) && $stable(fmt_q))); // R12

endmodule

// File: rtl/dm_phys_match.sv
module dm_phys_match
    import dm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_mode,
    input  logic [DEST_W-1:0] dest,
    input  logic [ID_W-1:0]   id,
    output logic              hit
);

    logic bcast;
    logic own;

    always_comb begin
        if (ext_mode) begin
            bcast = (dest == DEST_W'(PHYS_BCAST));
            own   = (dest == DEST_W'(id));
        end else begin
            bcast = (dest[ID_W-1:0] == PHYS_BCAST);
            own   = (dest[ID_W-1:0] == id);
        end
        hit = bcast || own;
    end

    AST_PHYS_BCAST_HIT: assert property (@(posedge clk) disable iff (rst)
        (!ext_mode && dest[ID_W-1:0] == 8'hFF) |-> hit); // R5

    AST_EXT_PHYS_ZERO_MISS: assert property (@(posedge clk) disable iff (rst)
        (ext_mode && dest[DEST_W-1:ID_W] != '0) |-> !hit); // R10

endmodule

// File: rtl/dm_logic_match.sv
module dm_logic_match
    import dm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_mode,
    input  logic [DEST_W-1:0] dest,
    input  cfg_t              cfg,
    output logic              hit
);

    logic [ID_W-1:0] lid;
    logic [ID_W-1:0] d8;
    logic            flat_hit;
    logic            clus_hit;
    logic            wide_hit;

    assign lid = cfg.ldr[DEST_W-1 -: ID_W];
    assign d8  = dest[ID_W-1:0];

    always_comb begin
        flat_hit = |(lid & d8);
        clus_hit = (lid[ID_W-1:NIB_W] == d8[ID_W-1:NIB_W]) &&
                   (|(lid[NIB_W-1:0] & d8[NIB_W-1:0]));
        wide_hit = |(cfg.ldr & dest);
        if (ext_mode)
            hit = wide_hit;
        else if (cfg.model == FMT_FLAT)
            hit = flat_hit;
        else if (cfg.model == FMT_CLUSTER)
            hit = clus_hit;
        else
            hit = 1'b0;
    end

    AST_BAD_FORMAT_MISS: assert property (@(posedge clk) disable iff (rst)
        (!ext_mode && cfg.model != 4'hF && cfg.model != 4'h0) |-> !hit); // R8

    AST_ZERO_DEST_MISS: assert property (@(posedge clk) disable iff (rst)
        (dest == '0) |-> !hit); // R6

endmodule

// File: rtl/dest_match_unit.sv
module dest_match_unit
    import dm_pkg::*;
#(
    parameter logic [7:0] RESET_ID = 8'h03
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ext_mode,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic [31:0] msg_dest,
    input  logic        msg_logical,
    input  logic [1:0]  msg_short,
    input  logic        msg_from_self,
    output logic        match
);

    cfg_t   cfg;
    logic   phys_hit;
    logic   logic_hit;
    short_e sh;

    assign sh = short_e'(msg_short);

    dm_cfg_regs #(.RESET_ID(RESET_ID)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .ext_mode (ext_mode),
        .wr_en    (wr_en),
        .wr_sel   (wsel_e'(wr_sel)),
        .wr_data  (wr_data),
        .cfg      (cfg)
    );

    dm_phys_match phys_i (
        .clk      (clk),
        .rst      (rst),
        .ext_mode (ext_mode),
        .dest     (msg_dest),
        .id       (cfg.id),
        .hit      (phys_hit)
    );

    dm_logic_match logic_i (
        .clk      (clk),
        .rst      (rst),
        .ext_mode (ext_mode),
        .dest     (msg_dest),
        .cfg      (cfg),
        .hit      (logic_hit)
    );

    always_comb begin
        unique case (sh)
            SH_DEST:   match = msg_logical ? logic_hit : phys_hit;
            SH_SELF:   match = msg_from_self;
            SH_ALL:    match = 1'b1;
            SH_OTHERS: match = !msg_from_self;
            default:   match = 1'b0;
        endcase
    end

    AST_SHORT_ADDR: assert property (@(posedge clk) disable iff (rst)
        (msg_short == 2'b00 && !msg_logical) |-> (match == phys_hit)); // R1

    AST_SHORT_SELF: assert property (@(posedge clk) disable iff (rst)
        (msg_short == 2'b01) |-> (match == msg_from_self)); // R2

    AST_SHORT_ALL: assert property (@(posedge clk) disable iff (rst)
        (msg_short == 2'b10) |-> match); // R3

    AST_SHORT_OTHERS: assert property (@(posedge clk) disable iff (rst)
        (msg_short == 2'b11) |-> (match != msg_from_self)); // R4

endmodule

// File: tb/dest_match_unit_tb.sv
module dest_match_unit_tb_top;

    localparam logic [7:0] RID = 8'h03;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'b11;
    logic [31:0] wr_data = '0;
    logic [31:0] msg_dest = '0;
    logic        msg_logical = 1'b0;
    logic [1:0]  msg_short = 2'b00;
    logic        msg_from_self = 1'b0;
    logic        match;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0]  m_id;
    logic [31:0] m_ldr;
    logic [3:0]  m_fmt;

    always #4 clk = ~clk;

    dest_match_unit #(.RESET_ID(RID)) dut_i (
        .clk(clk), .rst(rst), .ext_mode(ext_mode), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .msg_dest(msg_dest),
        .msg_logical(msg_logical), .msg_short(msg_short),
        .msg_from_self(msg_from_self), .match(match)
    );

    function automatic logic [31:0] ref_wide(input logic [7:0] id);
        return ({28'b0, id[7:4]} << 20) | (32'd1 << id[3:0]);
    endfunction

    function automatic logic ref_match();
        logic [7:0] l;
        l = m_ldr[31:24];
        case (msg_short)
            2'b01: return msg_from_self;
            2'b10: return 1'b1;
            2'b11: return !msg_from_self;
            default: ;
        endcase
        if (!msg_logical) begin
            if (ext_mode) return (msg_dest == 32'hFF) || (msg_dest == {24'b0, m_id});
            return (msg_dest[7:0] == 8'hFF) || (msg_dest[7:0] == m_id);
        end
        if (ext_mode) return (ref_wide(m_id) & msg_dest) != 0;
        if (m_fmt == 4'hF) return (l & msg_dest[7:0]) != 0;
        if (m_fmt == 4'h0) return (l[7:4] == msg_dest[7:4]) && ((l[3:0] & msg_dest[3:0]) != 0);
        return 1'b0;
    endfunction

    function automatic string ref_tag();
        case (msg_short)
            2'b01: return "R2";
            2'b10: return "R3";
            2'b11: return "R4";
            default: ;
        endcase
        if (!msg_logical) return ext_mode ? "R10" : "R5";
        if (ext_mode) return "R9";
        if (m_fmt == 4'hF) return "R6";
        if (m_fmt == 4'h0) return "R7";
        return "R8";
    endfunction

    task automatic check(input string tag);
        logic e;
        e = ref_match();
        n_checks++;
        if (match !== e) begin
            n_fail++;
            $display("FAIL %s (%s): match=%b expected=%b dest=%h log=%b sh=%b self=%b ext=%b",
                     tag, ref_tag(), match, e, msg_dest, msg_logical, msg_short,
                     msg_from_self, ext_mode);
        end
    endtask

    // drive at falling edge, check, then let the write land at the rising edge
    task automatic step(input string tag);
        #1;
        check(tag);
        @(posedge clk);
        if (wr_en && !ext_mode) begin
            case (wr_sel)
                2'b00: m_id  = wr_data[31:24];
                2'b01: m_ldr = wr_data;
                2'b10: m_fmt = wr_data[31:28];
                default: ;
            endcase
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic msg(input logic [31:0] d, input logic lg, input logic [1:0] sh, input logic sf);
        msg_dest = d; msg_logical = lg; msg_short = sh; msg_from_self = sf;
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seed;
        logic [31:0] r;
        seed = 17;
        r = $urandom(seed);
        m_id = RID; m_ldr = '0; m_fmt = 4'hF;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state: own ID matches physically, logical word is zero
        msg(32'h0000_0003, 1'b0, 2'b00, 1'b0); step("R11");
        msg(32'h0000_00FF, 1'b1, 2'b00, 1'b0); step("R11");
        // R5 upper destination bits ignored in legacy physical
        msg(32'hABCD_0003, 1'b0, 2'b00, 1'b0); step("R5");
        // R12 ID write, then LDR write, then flat R6
        msg(32'h0000_0003, 1'b0, 2'b00, 1'b0); wr(2'b00, 32'h2A00_0000); step("R12");
        msg(32'h0000_002A, 1'b0, 2'b00, 1'b0); step("R12");
        wr(2'b01, 32'h5100_0000); step("R12");
        msg(32'h0000_0040, 1'b1, 2'b00, 1'b0); step("R6");
        msg(32'h0000_00AE, 1'b1, 2'b00, 1'b0); step("R6");
        // R7 cluster format; low bits of write forced to ones (R11)
        wr(2'b10, 32'h0000_0000); step("R11");
        msg(32'h0000_0051, 1'b1, 2'b00, 1'b0); step("R7");
        msg(32'h0000_0041, 1'b1, 2'b00, 1'b0); step("R7");
        msg(32'h0000_0052, 1'b1, 2'b00, 1'b0); step("R7");
        // R8 other format
        wr(2'b10, 32'h7000_0000); step("R12");
        msg(32'h0000_0051, 1'b1, 2'b00, 1'b0); step("R8");
        // R12 select 11 does nothing
        wr(2'b11, 32'hFFFF_FFFF); step("R12");
        msg(32'h0000_0051, 1'b1, 2'b00, 1'b0); step("R12");
        // R9/R10/R13 extended mode
        ext_mode = 1'b1;
        msg(32'h0040_0000, 1'b1, 2'b00, 1'b0); step("R9");   // id 2A: cluster 2 -> bit 21, bit 10
        msg(32'h0020_0000, 1'b1, 2'b00, 1'b0); step("R9");
        msg(32'h0000_0400, 1'b1, 2'b00, 1'b0); step("R9");
        msg(32'h0000_002A, 1'b0, 2'b00, 1'b0); step("R10");
        msg(32'h0100_00FF, 1'b0, 2'b00, 1'b0); step("R10");
        wr(2'b00, 32'h5500_0000); step("R13");
        msg(32'h0000_002A, 1'b0, 2'b00, 1'b0); step("R13");
        ext_mode = 1'b0;
        // shorthands
        msg(32'h0, 1'b0, 2'b01, 1'b1); step("R2");
        msg(32'hFF, 1'b0, 2'b01, 1'b0); step("R2");
        msg(32'h0, 1'b1, 2'b10, 1'b0); step("R3");
        msg(32'h0, 1'b0, 2'b11, 1'b1); step("R4");
        msg(32'h0, 1'b0, 2'b11, 1'b0); step("R4");

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            int k;
            if ($urandom_range(199, 0) == 0) ext_mode = !ext_mode;
            k = $urandom_range(9, 0);
            if (k < 1) wr(2'b00, {$urandom_range(255, 0), 24'h0} << 0);
            else if (k < 2) wr(2'b01, $urandom());
            else if (k < 3) begin
                case ($urandom_range(2, 0))
                    0: wr(2'b10, {4'hF, 28'($urandom())});
                    1: wr(2'b10, {4'h0, 28'($urandom())});
                    default: wr(2'b10, $urandom());
                endcase
            end
            k = $urandom_range(5, 0);
            case (k)
                0: msg_dest = {24'b0, m_id};
                1: msg_dest = 32'hFF;
                2: msg_dest = {24'b0, m_ldr[31:24] ^ 8'($urandom_range(3, 0))};
                3: msg_dest = ref_wide(m_id) ^ (32'd1 << $urandom_range(31, 0));
                4: msg_dest = $urandom() & 32'h0000_01FF;
                default: msg_dest = $urandom();
            endcase
            msg_logical   = 1'($urandom_range(1, 0));
            msg_short     = ($urandom_range(3, 0) == 0) ? 2'($urandom_range(3, 1)) : 2'b00;
            msg_from_self = 1'($urandom_range(1, 0));
            step("R1");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule